// File: doc/BRIEF.md
# Windowed Coarse Frequency Discriminator

This block judges whether a recovered clock runs near enough to a local reference and, when it does not, says in which direction it is off. The recovered clock reaches the block as a pulse train that an upstream prescaler has slowed so that the reference can sample it. The block brings that pulse train into the reference domain, counts its rising edges over a fixed gate of reference cycles, and compares the total with a window centred on the nominal count. Too many edges means the recovered clock is fast and the correction output is driven low. Too few means it is slow and the output is driven high. Inside the window the output is released. The release is modelled as a data bit plus a drive enable.

A single mode input chooses the window. The narrow window of ±1% serves normal playback. The wide window of ±3% serves every other mode. The decision is registered once per gate and holds until the next gate ends. The surrounding loop uses it only for coarse pull-in, and a separate phase detector does the fine work.

Top module: `fdisc_window_top`

## Requirements
- R1: After reset the output is released (`disc_oe`=0, `disc_drv`=0). It stays released until the first full gate of `EXP_COUNT*REF_PER_PULSE` reference cycles has completed.
- R2: The block counts the rising edges of `meas_clk` after a two-flop synchroniser. It updates `disc_oe` and `disc_drv` only in the cycle after a gate ends, and holds them at every other time.
- R3: With `wide_mode`=0, a gate count of at least ceil(`EXP_COUNT`×1.01) sets `disc_oe`=1 and `disc_drv`=0, meaning the measured clock is fast.
- R4: With `wide_mode`=0, a gate count of at most floor(`EXP_COUNT`×0.99) sets `disc_oe`=1 and `disc_drv`=1, meaning the measured clock is slow.
- R5: With `wide_mode`=1, the fast and slow limits move out to ceil(`EXP_COUNT`×1.03) and floor(`EXP_COUNT`×0.97). The output polarity is the same as in R3 and R4.
- R6: A gate count strictly between the active slow and fast limits sets `disc_oe`=0 and `disc_drv`=0.
- R7: A change of `wide_mode` in the middle of a gate discards that partial gate and restarts the gate timer and edge count. The previous decision is held until the restarted gate ends, and that gate is judged with the new window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Reference clock; all logic runs on it |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| meas_clk | input | 1 | Prescaled recovered clock, asynchronous to `clk_ref` |
| wide_mode | input | 1 | 0: ±1% window (normal playback), 1: ±3% window |
| disc_drv | output | 1 | Correction level when driven: 0 = too fast, 1 = too slow |
| disc_oe | output | 1 | Drive enable; 0 means the output is released |

## Verification
The measured pulse train is swept at offsets of 0%, ±0.5%, ±2% and ±5% in both window modes. The ±0.5% offsets show that a small error never drives the output. The ±2% offsets are the cases that tell the two windows apart: they drive the output in the narrow window and release it in the wide one. The ±5% offsets confirm the polarity of both drive directions. Separate scenarios start with a fast input held across reset, to show that nothing is driven before the first gate ends. They also switch the mode shortly after a gate boundary, which shows that the old decision outlives a boundary that would otherwise have fallen in that interval.

// File: rtl/fdisc_pkg.sv
package fdisc_pkg;

  // Fast limit: smallest count at or above nominal*(100+pct)/100.
  function automatic int fast_limit(input int nominal, input int pct);
    return (nominal * (100 + pct) + 99) / 100;
  endfunction

  // Slow limit: largest count at or below nominal*(100-pct)/100.
  function automatic int slow_limit(input int nominal, input int pct);
    return (nominal * (100 - pct)) / 100;
  endfunction

  typedef enum logic [1:0] {
    VERD_INSIDE = 2'd0,
    VERD_FAST   = 2'd1,
    VERD_SLOW   = 2'd2
  } verdict_e;

endpackage

// File: rtl/fdisc_pulse_sync.sv
module fdisc_pulse_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic rise_o
);

  logic [STAGES-1:0] stage_q;
  logic [STAGES-1:0] stage_d;
  logic              prev_q;

  always_comb begin
    stage_d[0] = async_i;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_chain
    always_comb stage_d[g] = stage_q[g-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      stage_q <= stage_d;
      prev_q  <= stage_q[STAGES-1];
    end
  end

  assign rise_o = stage_q[STAGES-1] & ~prev_q;

endmodule

// File: rtl/fdisc_gate_timer.sv
module fdisc_gate_timer #(
  parameter int GATE_CYC = 16384,
  localparam int TW = (GATE_CYC > 1) ? $clog2(GATE_CYC) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart_i,
  output logic          tick_o,
  output logic [TW-1:0] cnt_o
);

  localparam logic [TW-1:0] LAST = TW'(GATE_CYC - 1);

  logic [TW-1:0] cnt_q;
  logic [TW-1:0] cnt_d;

  always_comb begin
    tick_o = (cnt_q == LAST);
    if (restart_i || tick_o) cnt_d = '0;
    else                     cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/fdisc_edge_counter.sv
module fdisc_edge_counter #(
  parameter int CW = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          edge_i,
  input  logic          gate_end_i,
  input  logic          restart_i,
  output logic [CW-1:0] total_o
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          clr;

  always_comb begin
    total_o = cnt_q + CW'(edge_i);
    clr     = gate_end_i | restart_i;
    cnt_d   = clr ? '0 : total_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/fdisc_classify.sv
module fdisc_classify
  import fdisc_pkg::*;
#(
  parameter int EXP_COUNT  = 4096,
  parameter int NARROW_PCT = 1,
  parameter int WIDE_PCT   = 3,
  parameter int CW         = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] total_i,
  input  logic          gate_end_i,
  input  logic          wide_i,
  output logic          oe_o,
  output logic          drv_o
);

  localparam logic [CW-1:0] FAST_N = CW'(fast_limit(EXP_COUNT, NARROW_PCT));
  localparam logic [CW-1:0] SLOW_N = CW'(slow_limit(EXP_COUNT, NARROW_PCT));
  localparam logic [CW-1:0] FAST_W = CW'(fast_limit(EXP_COUNT, WIDE_PCT));
  localparam logic [CW-1:0] SLOW_W = CW'(slow_limit(EXP_COUNT, WIDE_PCT));

  logic [CW-1:0] fast_lim;
  logic [CW-1:0] slow_lim;
  verdict_e      verdict;
  logic          upd_en;
  logic          oe_q, drv_q, oe_d, drv_d;

  always_comb begin
    fast_lim = wide_i ? FAST_W : FAST_N;
    slow_lim = wide_i ? SLOW_W : SLOW_N;
    if (total_i >= fast_lim)      verdict = VERD_FAST;
    else if (total_i <= slow_lim) verdict = VERD_SLOW;
    else                          verdict = VERD_INSIDE;
  end

  always_comb begin
    upd_en = gate_end_i;
    oe_d   = oe_q;
    drv_d  = drv_q;
    if (upd_en) begin
      unique case (verdict)
        VERD_FAST: begin oe_d = 1'b1; drv_d = 1'b0; end
        VERD_SLOW: begin oe_d = 1'b1; drv_d = 1'b1; end
        default:   begin oe_d = 1'b0; drv_d = 1'b0; end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_q  <= 1'b0;
      drv_q <= 1'b0;
    end else begin
      oe_q  <= oe_d;
      drv_q <= drv_d;
    end
  end

  assign oe_o  = oe_q;
  assign drv_o = drv_q;

endmodule

// File: rtl/fdisc_window_top.sv
module fdisc_window_top #(
  parameter int EXP_COUNT     = 4096,
  parameter int REF_PER_PULSE = 4,
  parameter int NARROW_PCT    = 1,
  parameter int WIDE_PCT      = 3,
  parameter int SYNC_STAGES   = 2,
  localparam int GATE_CYC = EXP_COUNT * REF_PER_PULSE,
  localparam int TW       = (GATE_CYC > 1) ? $clog2(GATE_CYC) : 1,
  localparam int CW       = $clog2(GATE_CYC + 1)
) (
  input  logic clk_ref,
  input  logic rst_n,
  input  logic meas_clk,
  input  logic wide_mode,
  output logic disc_drv,
  output logic disc_oe
);

  // Reset: asserted asynchronously, released on the reference clock.
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  // Mode register; any change restarts the gate.
  logic mode_q, mode_d, restart;

  always_comb begin
    restart = (wide_mode != mode_q);
    mode_d  = wide_mode;
  end

  always_ff @(posedge clk_ref or negedge rst_sync_n) begin
    if (!rst_sync_n) mode_q <= 1'b0;
    else             mode_q <= mode_d;
  end

  logic          meas_rise;
  logic          tick;
  logic          gate_end;
  logic [TW-1:0] timer_cnt;
  logic [CW-1:0] total;

  fdisc_pulse_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk_ref),
    .rst_n   (rst_sync_n),
    .async_i (meas_clk),
    .rise_o  (meas_rise)
  );

  fdisc_gate_timer #(.GATE_CYC(GATE_CYC)) u_gate (
    .clk       (clk_ref),
    .rst_n     (rst_sync_n),
    .restart_i (restart),
    .tick_o    (tick),
    .cnt_o     (timer_cnt)
  );

  assign gate_end = tick & ~restart;

  fdisc_edge_counter #(.CW(CW)) u_count (
    .clk        (clk_ref),
    .rst_n      (rst_sync_n),
    .edge_i     (meas_rise),
    .gate_end_i (gate_end),
    .restart_i  (restart),
    .total_o    (total)
  );

  fdisc_classify #(
    .EXP_COUNT  (EXP_COUNT),
    .NARROW_PCT (NARROW_PCT),
    .WIDE_PCT   (WIDE_PCT),
    .CW         (CW)
  ) u_class (
    .clk        (clk_ref),
    .rst_n      (rst_sync_n),
    .total_i    (total),
    .gate_end_i (gate_end),
    .wide_i     (mode_q),
    .oe_o       (disc_oe),
    .drv_o      (disc_drv)
  );

endmodule

// File: rtl/fdisc_window_chk.sv
module fdisc_window_chk
  import fdisc_pkg::*;
#(
  parameter int EXP_COUNT  = 4096,
  parameter int NARROW_PCT = 1,
  parameter int WIDE_PCT   = 3,
  parameter int TW         = 14,
  parameter int CW         = 15
) (
  input logic          clk,
  input logic          rst_n,
  input logic          gate_end,
  input logic          restart,
  input logic          mode_q,
  input logic [TW-1:0] timer_cnt,
  input logic [CW-1:0] total,
  input logic          oe,
  input logic          drv
);

  localparam int FN = fast_limit(EXP_COUNT, NARROW_PCT);
  localparam int SN = slow_limit(EXP_COUNT, NARROW_PCT);
  localparam int FW = fast_limit(EXP_COUNT, WIDE_PCT);
  localparam int SW = slow_limit(EXP_COUNT, WIDE_PCT);

  logic first_done_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        first_done_q <= 1'b0;
    else if (gate_end) first_done_q <= 1'b1;
  end

  logic is_fast, is_slow;
  always_comb begin
    is_fast = int'(total) >= (mode_q ? FW : FN);
    is_slow = int'(total) <= (mode_q ? SW : SN);
  end

  // R1
  released_before_first_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !first_done_q |-> !oe);

  // R2
  hold_between_gates_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !gate_end |=> $stable(oe) && $stable(drv));

  // R3
  fast_drives_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gate_end && is_fast |=> oe && !drv);

  // R4
  slow_drives_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gate_end && !is_fast && is_slow |=> oe && drv);

  // R6
  inside_releases_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gate_end && !is_fast && !is_slow |=> !oe && !drv);

  // R7
  mode_change_restarts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> timer_cnt == '0);

endmodule

bind fdisc_window_top fdisc_window_chk #(
  .EXP_COUNT  (EXP_COUNT),
  .NARROW_PCT (NARROW_PCT),
  .WIDE_PCT   (WIDE_PCT),
  .TW         (TW),
  .CW         (CW)
) u_chk (
  .clk       (clk_ref),
  .rst_n     (rst_sync_n),
  .gate_end  (gate_end),
  .restart   (restart),
  .mode_q    (mode_q),
  .timer_cnt (timer_cnt),
  .total     (total),
  .oe        (disc_oe),
  .drv       (disc_drv)
);

// File: tb/test_fdisc_window_top.sv
module test_fdisc_window_top;

  localparam int EXP  = 1024;
  localparam int RPP  = 4;
  localparam int GATE = EXP * RPP;

  logic clk_ref = 1'b0;
  logic rst_n;
  logic meas_clk;
  logic wide_mode;
  logic disc_drv;
  logic disc_oe;

  int tests_run = 0;
  int tests_failed = 0;

  always #5 clk_ref = ~clk_ref;

  fdisc_window_top #(.EXP_COUNT(EXP), .REF_PER_PULSE(RPP)) i_fdisc_window_top (
    .clk_ref   (clk_ref),
    .rst_n     (rst_n),
    .meas_clk  (meas_clk),
    .wide_mode (wide_mode),
    .disc_drv  (disc_drv),
    .disc_oe   (disc_oe)
  );

  // Phase-accumulator pulse source: nominal period RPP reference cycles.
  logic [15:0] phase = 16'd0;
  int          step  = 16384;
  always @(negedge clk_ref) phase <= phase + 16'(step);
  assign meas_clk = phase[15];

  task automatic set_offset(input int permille);
    step = (16384 * (1000 + permille)) / 1000;
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_ref);
  endtask

  task automatic check(input string req, input logic exp_oe, input logic exp_drv);
    tests_run++;
    if (disc_oe !== exp_oe || (exp_oe && disc_drv !== exp_drv)) begin
      tests_failed++;
      $display("FAIL %s: oe=%b drv=%b expected oe=%b drv=%b",
               req, disc_oe, disc_drv, exp_oe, exp_drv);
    end
  endtask

  // R1: fast input across reset, nothing driven before first gate ends
  task automatic t_reset();
    rst_n = 1'b0;
    wide_mode = 1'b0;
    set_offset(50);
    wait_cyc(5);
    check("R1 during reset", 1'b0, 1'b0);
    rst_n = 1'b1;
    wait_cyc(GATE - 20);
    check("R1 before first gate", 1'b0, 1'b0);
    wait_cyc(40);
    check("R1/R3 after first gate", 1'b1, 1'b0);
  endtask

  // R3 R4 R5 R6: sweep of offsets, window chosen by mode
  task automatic t_sweep(input logic wide);
    int offs[7] = '{0, 5, -5, 20, -20, 50, -50};
    int lim;
    logic eo, ed;
    lim = wide ? 30 : 10;
    wide_mode = wide;
    foreach (offs[k]) begin
      set_offset(offs[k]);
      wait_cyc(2 * GATE + 50);
      eo = (offs[k] >= lim) || (offs[k] <= -lim);
      ed = (offs[k] <= -lim);
      if (wide) check($sformatf("R5/R6 wide off=%0d permille", offs[k]), eo, ed);
      else      check($sformatf("R3/R4/R6 narrow off=%0d permille", offs[k]), eo, ed);
    end
  endtask

  // R7 R2: mode change shortly after a boundary holds old decision one full gate
  task automatic t_mode_change();
    int guard;
    wide_mode = 1'b0;
    set_offset(0);
    wait_cyc(2 * GATE + 50);
    check("R6 narrow 0% before mode test", 1'b0, 1'b0);
    set_offset(20);
    guard = 0;
    while (!disc_oe && guard < 3 * GATE) begin
      @(negedge clk_ref);
      guard++;
    end
    check("R3 narrow +2% boundary seen", 1'b1, 1'b0);
    wait_cyc(100);
    wide_mode = 1'b1;
    wait_cyc(GATE - 20);
    check("R7/R2 decision held after mode change", 1'b1, 1'b0);
    wait_cyc(40);
    check("R7/R5 restarted gate judged wide", 1'b0, 1'b0);
  endtask

  initial begin
    t_reset();
    t_sweep(1'b0);
    t_sweep(1'b1);
    t_mode_change();
    $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end

  initial begin
    wait_cyc(190000);
    tests_failed++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end

endmodule